// File: doc/BRIEF.md
# Power-Management and SMBus Host Register Window

This block answers I/O-space accesses for two address windows, picked by a pair of window-select inputs that come from the host bridge's base-address decode. The power-management window is 64 bytes of byte-addressable storage. The exception is a free-running 32-bit timer, which advances on a tick-enable input pulsed at the fixed 3.579545 MHz power-management rate. The SMBus host window is 32 bytes of storage. Its host-status byte behaves as if every transaction finished at once.

Accesses are 1, 2 or 4 bytes wide, little-endian, and may start at any offset. The block performs no bus signalling and generates no events. Status bytes are plain read/write storage. Firmware and drivers see stable registers, a monotonic timer for delay calibration, and an SMBus controller that never reports busy.

Top module: `pmsmb_regs`

## Requirements
- R1: After reset every stored byte in both windows is 0x00, the timer count is 0 and `rdata_o` is 0.
- R2: `size_i` encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Data byte i (bits 8i+7:8i) maps to window offset `off_i`+i. Read lanes above the access width return zero.
- R3: When `sel_pm_i` is set, the access targets the 64-byte power-management window, addressed by `off_i[5:0]`. Every byte there, including the status bytes at 0x00–0x01, is plain storage: the written value reads back unchanged, with no write-one-to-clear behaviour.
- R4: A write byte whose offset lies past the end of its window is dropped. A read byte past the end reads as zero. Offsets do not wrap.
- R5: The timer increments by one in each cycle in which `tick_i` is high, holds otherwise, and wraps modulo 2^32.
- R6: A 4-byte read of the power-management window at offset 0x08 returns the timer value held before that cycle's tick. Any other read size at 0x08 returns the stored bytes. Writes to 0x08–0x0B update only the stored bytes.
- R7: When `sel_smb_i` is set and `sel_pm_i` is clear, the access targets the 32-byte SMBus window, addressed by `off_i[4:0]`. Bit 5 of the offset is ignored.
- R8: After any write that covers SMBus offset 0x00, status bit 0 (busy) reads 0 and bit 1 (done) reads 1, whatever data was written. Bits 7:2 take the written data.
- R9: Read data appears on `rdata_o` in the cycle after `rd_i`. It is zero after cycles with no read. When both selects are high, `sel_pm_i` wins. With neither select high, reads return zero and writes change nothing.
- R10: `size_i` = 3 moves no bytes: a write with it changes nothing and a read with it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_pm_i | input | 1 | Access targets the power-management window |
| sel_smb_i | input | 1 | Access targets the SMBus window |
| off_i | input | 6 | Byte offset within the window |
| size_i | input | 2 | Access width code |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data, little-endian |
| tick_i | input | 1 | Timer increment enable, pulsed at the timer rate |
| rdata_o | output | 32 | Read data, one cycle after `rd_i` |

## Verification
The checker watches the timer on every cycle. It confirms a single-step increment on each tick, a held count otherwise, and modular wrap, which no bench run could reach in full. It also checks on every cycle that the done/busy status pattern follows each SMBus status write, that idle and invalid-size reads return zero, and that the upper lanes of 1-byte reads are zero. Only the bench scenarios show the rest. These are the byte-lane mapping at arbitrary offsets, truncation at a window end, offset aliasing in the SMBus window, the split behaviour of offset 0x08 between timer and storage, and select priority. The bench checks them against a byte-level model of both windows.

// File: rtl/pmsmb_pkg.sv
package pmsmb_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned LANES = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pmsmb_tmr.sv
module pmsmb_tmr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/pmsmb_byte_store.sv
module pmsmb_byte_store
  import pmsmb_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter bit          STS_FORCE = 1'b0,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] off_i,
  input  logic [2:0]    nb_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [7:0]    b0_o
);
  logic [7:0] mem_q [DEPTH];
  logic [AW+1:0] ix [LANES];
  logic [LANES-1:0] ln_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ix[g]    = {2'b00, off_i} + (AW+2)'(g);
    assign ln_ok[g] = (3'(g) < nb_i) && (ix[g] < (AW+2)'(DEPTH));
    assign rdata_o[8*g +: 8] = ln_ok[g] ? mem_q[ix[g][AW-1:0]] : 8'h00;
  end

  assign b0_o = mem_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      for (int i = 0; i < LANES; i++)
        if (ln_ok[i]) mem_q[ix[i][AW-1:0]] <= wdata_i[8*i +: 8];
      // host status: transaction reported complete at once
      if (STS_FORCE && off_i == '0 && nb_i != 3'd0)
        mem_q[0] <= {wdata_i[7:2], 2'b10};
    end
  end
endmodule

// File: rtl/pmsmb_regs.sv
module pmsmb_regs
  import pmsmb_pkg::*;
#(
  parameter int unsigned PM_BYTES  = 64,
  parameter int unsigned SMB_BYTES = 32,
  parameter int unsigned TMR_OFF   = 8,
  parameter int unsigned TMR_W     = 32,
  localparam int unsigned PM_AW    = $clog2(PM_BYTES),
  localparam int unsigned SMB_AW   = $clog2(SMB_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_pm_i,
  input  logic             sel_smb_i,
  input  logic [PM_AW-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             tick_i,
  output logic [DW-1:0]    rdata_o
);
  logic [2:0]       nb;
  logic             hit_pm, hit_smb, tmr_hit;
  logic [TMR_W-1:0] tmr_q;
  logic [DW-1:0]    pm_rd, smb_rd, rd_mux;
  logic [7:0]       pm_b0, smb_b0;

  assign nb      = size_bytes(size_i);
  assign hit_pm  = sel_pm_i;
  assign hit_smb = sel_smb_i && !sel_pm_i;
  assign tmr_hit = off_i == PM_AW'(TMR_OFF) && acc_size_e'(size_i) == SZ_WORD;

  pmsmb_tmr #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (tmr_q)
  );

  pmsmb_byte_store #(.DEPTH(PM_BYTES), .STS_FORCE(1'b0)) u_pm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && hit_pm),
    .off_i   (off_i),
    .nb_i    (nb),
    .wdata_i (wdata_i),
    .rdata_o (pm_rd),
    .b0_o    (pm_b0)
  );

  pmsmb_byte_store #(.DEPTH(SMB_BYTES), .STS_FORCE(1'b1)) u_smb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && hit_smb),
    .off_i   (off_i[SMB_AW-1:0]),
    .nb_i    (nb),
    .wdata_i (wdata_i),
    .rdata_o (smb_rd),
    .b0_o    (smb_b0)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_pm)       rd_mux = tmr_hit ? DW'(tmr_q) : pm_rd;
    else if (hit_smb) rd_mux = smb_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/pmsmb_regs_chk.sv
module pmsmb_regs_chk #(
  parameter int unsigned TMR_W = 32,
  parameter int unsigned AW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_pm_i,
  input logic             sel_smb_i,
  input logic [AW-1:0]    off_i,
  input logic [1:0]       size_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic             tick_i,
  input logic [31:0]      rdata_o,
  input logic [TMR_W-1:0] tmr_i,
  input logic [7:0]       smb_b0_i
);
  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> tmr_i == $past(tmr_i) + TMR_W'(1)); // R5
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tmr_i)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == 32'h0); // R9
  AST_BYTE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == 2'd0) |=> rdata_o[31:8] == 24'h0); // R2
  AST_SMB_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_pm_i && sel_smb_i && off_i[4:0] == 5'd0 && size_i != 2'd3)
      |=> smb_b0_i[1:0] == 2'b10); // R8
  AST_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == 2'd3) |=> rdata_o == 32'h0); // R10
endmodule

bind pmsmb_regs pmsmb_regs_chk #(.TMR_W(TMR_W), .AW(PM_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_pm_i  (sel_pm_i),
  .sel_smb_i (sel_smb_i),
  .off_i     (off_i),
  .size_i    (size_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .tick_i    (tick_i),
  .rdata_o   (rdata_o),
  .tmr_i     (tmr_q),
  .smb_b0_i  (smb_b0)
);

// File: tb/sim_pmsmb_regs.sv
module sim_pmsmb_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_pm = 1'b0, sel_smb = 1'b0, wr = 1'b0, rd = 1'b0, tick = 1'b0;
  logic [5:0]  off = '0;
  logic [1:0]  sz = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  pm_m [64];
  logic [7:0]  smb_m [32];
  logic [31:0] tmr_m = '0;

  always #5 clk = ~clk;

  pmsmb_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_pm_i(sel_pm), .sel_smb_i(sel_smb),
    .off_i(off), .size_i(sz), .wr_i(wr), .rd_i(rd), .wdata_i(wd),
    .tick_i(tick), .rdata_o(rdata)
  );

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
  endfunction

  function automatic logic [31:0] mread(input bit sp, input bit ss,
                                        input logic [5:0] o, input logic [1:0] s);
    logic [31:0] v = '0;
    if (sp) begin
      if (o == 6'd8 && s == 2'd2) return tmr_m;
      for (int i = 0; i < nbytes(s); i++)
        if (int'(o) + i < 64) v[8*i +: 8] = pm_m[int'(o) + i];
    end else if (ss) begin
      for (int i = 0; i < nbytes(s); i++)
        if (int'(o[4:0]) + i < 32) v[8*i +: 8] = smb_m[int'(o[4:0]) + i];
    end
    return v;
  endfunction

  task automatic mwrite(input bit sp, input bit ss, input logic [5:0] o,
                        input logic [1:0] s, input logic [31:0] d);
    if (sp) begin
      for (int i = 0; i < nbytes(s); i++)
        if (int'(o) + i < 64) pm_m[int'(o) + i] = d[8*i +: 8];
    end else if (ss) begin
      for (int i = 0; i < nbytes(s); i++)
        if (int'(o[4:0]) + i < 32) smb_m[int'(o[4:0]) + i] = d[8*i +: 8];
      if (o[4:0] == 5'd0 && nbytes(s) > 0) smb_m[0] = {d[7:2], 2'b10};
    end
  endtask

  function automatic string auto_tag(input bit sp, input bit ss, input logic [5:0] o,
                                     input logic [1:0] s, input bit r);
    if (!r) return "R9";
    if (s == 2'd3) return "R10";
    if (sp) return (o == 6'd8) ? "R6" : "R3";
    if (ss) return "R7";
    return "R9";
  endfunction

  // one cycle: drive at negedge, compare registered read at the next negedge
  task automatic cyc(input bit sp, input bit ss, input logic [5:0] o, input logic [1:0] s,
                     input bit w, input bit r, input logic [31:0] d, input bit tk,
                     input string tag);
    logic [31:0] exp;
    exp = r ? mread(sp, ss, o, s) : 32'h0;
    sel_pm = sp; sel_smb = ss; off = o; sz = s; wr = w; rd = r; wd = d; tick = tk;
    if (w) mwrite(sp, ss, o, s, d);
    if (tk) tmr_m = tmr_m + 32'd1;
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: off=%h size=%0d got %h expected %h", tag, o, s, rdata, exp);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) pm_m[i] = 8'h00;
    for (int i = 0; i < 32; i++) smb_m[i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cyc(0, 0, 6'd0, 2'd0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 6'd0, 2'd2, 0, 1, 0, 0, "R1");
    cyc(1, 0, 6'd8, 2'd2, 0, 1, 0, 0, "R1");
    cyc(0, 1, 6'd0, 2'd2, 0, 1, 0, 0, "R1");

    // R3: status bytes are plain storage
    cyc(1, 0, 6'd0, 2'd1, 1, 0, 32'h0000_a5ff, 0, "R3");
    cyc(1, 0, 6'd0, 2'd1, 1, 0, 32'h0000_00ff, 0, "R3");
    cyc(1, 0, 6'd0, 2'd2, 0, 1, 0, 0, "R3");

    // R2: lanes at unaligned offset, byte read upper lanes zero
    cyc(1, 0, 6'd19, 2'd2, 1, 0, 32'h4433_2211, 0, "R2");
    cyc(1, 0, 6'd20, 2'd0, 0, 1, 0, 0, "R2");
    cyc(1, 0, 6'd21, 2'd1, 0, 1, 0, 0, "R2");

    // R4: truncation at window end
    cyc(1, 0, 6'd62, 2'd2, 1, 0, 32'hdead_beef, 0, "R4");
    cyc(1, 0, 6'd62, 2'd2, 0, 1, 0, 0, "R4");
    cyc(0, 1, 6'd31, 2'd2, 1, 0, 32'h7766_5544, 0, "R4");
    cyc(0, 1, 6'd30, 2'd2, 0, 1, 0, 0, "R4");

    // R5: ticks advance the timer, idle cycles hold it
    for (int i = 0; i < 7; i++) cyc(0, 0, 6'd0, 2'd0, 0, 0, 0, 1, "R5");
    cyc(0, 0, 6'd0, 2'd0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 6'd8, 2'd2, 0, 1, 0, 1, "R5");
    cyc(1, 0, 6'd8, 2'd2, 0, 1, 0, 0, "R5");

    // R6: writes at 0x08 land in storage; narrow reads see storage
    cyc(1, 0, 6'd8, 2'd2, 1, 0, 32'hcafe_f00d, 0, "R6");
    cyc(1, 0, 6'd8, 2'd1, 0, 1, 0, 0, "R6");
    cyc(1, 0, 6'd8, 2'd0, 0, 1, 0, 0, "R6");
    cyc(1, 0, 6'd8, 2'd2, 0, 1, 0, 0, "R6");
    cyc(1, 0, 6'd10, 2'd1, 0, 1, 0, 0, "R6");

    // R8: status busy/done forced; R7 alias through offset bit 5
    cyc(0, 1, 6'd0, 2'd0, 1, 0, 32'h0000_00fd, 0, "R8");
    cyc(0, 1, 6'd0, 2'd0, 0, 1, 0, 0, "R8");
    cyc(0, 1, 6'd32, 2'd1, 1, 0, 32'h0000_3301, 0, "R7");
    cyc(0, 1, 6'd0, 2'd1, 0, 1, 0, 0, "R8");
    cyc(0, 1, 6'd33, 2'd0, 0, 1, 0, 0, "R7");

    // R9: select priority and unselected accesses
    cyc(1, 1, 6'd4, 2'd1, 1, 0, 32'h0000_5a5a, 0, "R9");
    cyc(0, 1, 6'd4, 2'd1, 0, 1, 0, 0, "R9");
    cyc(1, 0, 6'd4, 2'd1, 0, 1, 0, 0, "R9");
    cyc(0, 0, 6'd4, 2'd2, 1, 0, 32'h1234_5678, 0, "R9");
    cyc(0, 0, 6'd4, 2'd2, 0, 1, 0, 0, "R9");
    cyc(1, 0, 6'd4, 2'd2, 0, 1, 0, 0, "R9");

    // R10: invalid size moves nothing
    cyc(1, 0, 6'd12, 2'd3, 1, 0, 32'hffff_ffff, 0, "R10");
    cyc(1, 0, 6'd12, 2'd2, 0, 1, 0, 0, "R10");
    cyc(1, 0, 6'd12, 2'd3, 0, 1, 0, 0, "R10");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit sp, ss, w, r, tk;
      logic [5:0] o;
      logic [1:0] s;
      logic [31:0] d;
      sp = ($urandom % 2) == 0;
      ss = ($urandom % 4) != 0;
      o  = ($urandom % 5 == 0) ? 6'd8 : 6'($urandom);
      s  = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      w  = ($urandom % 2) == 0;
      r  = ($urandom % 3) != 0;
      d  = $urandom;
      tk = ($urandom % 3) == 0;
      cyc(sp, ss, o, s, w, r, d, tk, auto_tag(sp, ss, o, s, r));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule